// File: doc/BRIEF.md
# I2C Controller Command and Receive Queue

This block sits between software and the byte-level sequencer of an I2C controller. Software pushes 11-bit command words into a transmit queue. Each word either supplies one byte to send or asks for one byte to be read back. Each word can also ask for a repeated START before its byte, a STOP after its byte, or both. The oldest word is offered to the sequencer over a valid/ready handshake. Bytes the sequencer receives are queued in a receive queue, and software drains that queue one byte at a time.

The fill level of each queue is exposed on the ports. Each queue has a programmable threshold and a status flag derived from it, so software can refill or drain in bursts. Three one-cycle error pulses report a write into a full transmit queue, a push into a full receive queue, and a read from an empty receive queue. An abort input empties both queues at once, which discards everything belonging to a failed transfer.

Top module: `i2cm_cmd_queue`

## Requirements
- R1: A command word is decoded as data in bits 7:0, read request in bit 8, STOP-after in bit 9 and repeated-START-before in bit 10. Words are offered to the sequencer in the order they were written.
- R2: When the offered word is a read request, the data byte presented to the sequencer is 0x00, whatever was written in bits 7:0.
- R3: `tx_level` and `rx_level` give the current number of entries in each queue. They change in the cycle after an accepted push or pop, and both read 0 after reset.
- R4: `tx_low` is 1 exactly when `tx_level` is less than or equal to `tx_thresh`.
- R5: `rx_high` is 1 exactly when `rx_level` is greater than `rx_thresh`. A threshold of 0 therefore flags as soon as one byte is held.
- R6: A cycle with `abort` high empties both queues. Both levels read 0 on the next cycle, `seq_valid` drops, and any push or pop in that cycle is discarded.
- R7: `rx_data` always shows the oldest received byte. A cycle with `rx_rd_en` high on a non-empty queue removes that byte.
- R8: A write while the transmit queue is full drops the word, leaves `tx_level` unchanged, and raises `err_tx_over` for one cycle.
- R9: A read while the receive queue is empty leaves `rx_level` at 0 and raises `err_rx_under` for one cycle.
- R10: A received byte that arrives while the receive queue is full is dropped, and `err_rx_over` rises for one cycle.
- R11: While `seq_valid` is high and `seq_ready` is low, the offered word holds steady. Each cycle with both high removes exactly one word.
- R12: After reset, `seq_valid`, `tx_low`-independent error pulses and `rx_high` are 0, and `tx_low` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_wr_en | input | 1 | Push `cmd_word` into the transmit queue |
| cmd_word | input | 11 | Command word: restart(10), stop(9), read(8), data(7:0) |
| rx_rd_en | input | 1 | Pop the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| tx_thresh | input | LW | Transmit low-water threshold |
| rx_thresh | input | LW | Receive high-water threshold |
| tx_level | output | LW | Transmit queue entry count |
| rx_level | output | LW | Receive queue entry count |
| tx_low | output | 1 | Transmit level at or below threshold |
| rx_high | output | 1 | Receive level above threshold |
| abort | input | 1 | Empty both queues |
| seq_valid | output | 1 | A command is offered to the sequencer |
| seq_ready | input | 1 | Sequencer accepts the offered command |
| seq_data | output | 8 | Byte to send (0 for reads) |
| seq_read | output | 1 | Offered command is a read request |
| seq_stop | output | 1 | Issue STOP after this byte |
| seq_restart | output | 1 | Issue repeated START before this byte |
| seq_rx_valid | input | 1 | Sequencer delivers a received byte |
| seq_rx_byte | input | 8 | Received byte |
| err_tx_over | output | 1 | Pulse: write into full transmit queue |
| err_rx_over | output | 1 | Pulse: received byte dropped |
| err_rx_under | output | 1 | Pulse: read from empty receive queue |

LW is $clog2(DEPTH+1); 4 at the default depth of 8.

## Verification
A corrupted pointer or count shows up at the ports in the next cycle. `tx_level` or `rx_level` goes wrong, the threshold flags flip at the wrong fill, and the word or byte at the head comes out of order. The bench therefore compares the head of each queue against a written sequence after every pop, including a pop across the pointer wrap after an overflow attempt. A drop or flush fault that keeps the count right would still put a stale word at the head, and the next comparison reveals it.

// File: rtl/i2cm_q_pkg.sv
package i2cm_q_pkg;
  localparam int CMD_W = 11;

  typedef struct packed {
    logic       restart;
    logic       stop;
    logic       read;
    logic [7:0] data;
  } cmd_word_t;
endpackage

// File: rtl/i2cm_q_fifo.sv
module i2cm_q_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] head,
  output logic [LW-1:0]    level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_ptr_nxt, rd_ptr_nxt;
  logic [LW-1:0]    cnt, cnt_nxt;
  logic             wr_ok, rd_ok;

  assign full  = (cnt == LW'(DEPTH));
  assign empty = (cnt == '0);
  assign head  = mem[rd_ptr];
  assign level = cnt;

  always_comb begin
    wr_ok      = push && !full && !flush;
    rd_ok      = pop && !empty && !flush;
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    cnt_nxt    = cnt;
    if (flush) begin
      wr_ptr_nxt = '0;
      rd_ptr_nxt = '0;
      cnt_nxt    = '0;
    end else begin
      if (wr_ok) wr_ptr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (rd_ok) rd_ptr_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (wr_ok && !rd_ok)      cnt_nxt = cnt + 1'b1;
      else if (rd_ok && !wr_ok) cnt_nxt = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      cnt    <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= push_data;
  end

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LW'(DEPTH));

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));

  // R8 / R10: a push into a full queue leaves the count untouched
  assert_drop_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (level == $past(level)));
endmodule

// File: rtl/i2cm_q_status.sv
module i2cm_q_status #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_thresh,
  input  logic [LW-1:0] rx_thresh,
  input  logic          tx_full,
  input  logic          rx_full,
  input  logic          rx_empty,
  input  logic          tx_push,
  input  logic          rx_push,
  input  logic          rx_pop,
  input  logic          flush,
  output logic          tx_low,
  output logic          rx_high,
  output logic          err_tx_over,
  output logic          err_rx_over,
  output logic          err_rx_under
);
  logic tx_over_nxt, rx_over_nxt, rx_under_nxt;

  assign tx_low  = (tx_level <= tx_thresh);
  assign rx_high = (rx_level > rx_thresh);

  always_comb begin
    tx_over_nxt  = tx_push && tx_full && !flush;
    rx_over_nxt  = rx_push && rx_full && !flush;
    rx_under_nxt = rx_pop && rx_empty && !flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_tx_over  <= 1'b0;
      err_rx_over  <= 1'b0;
      err_rx_under <= 1'b0;
    end else begin
      err_tx_over  <= tx_over_nxt;
      err_rx_over  <= rx_over_nxt;
      err_rx_under <= rx_under_nxt;
    end
  end
endmodule

// File: rtl/i2cm_cmd_queue.sv
module i2cm_cmd_queue
  import i2cm_q_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr_en,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             rx_rd_en,
  output logic [7:0]       rx_data,
  input  logic [LW-1:0]    tx_thresh,
  input  logic [LW-1:0]    rx_thresh,
  output logic [LW-1:0]    tx_level,
  output logic [LW-1:0]    rx_level,
  output logic             tx_low,
  output logic             rx_high,
  input  logic             abort,
  output logic             seq_valid,
  input  logic             seq_ready,
  output logic [7:0]       seq_data,
  output logic             seq_read,
  output logic             seq_stop,
  output logic             seq_restart,
  input  logic             seq_rx_valid,
  input  logic [7:0]       seq_rx_byte,
  output logic             err_tx_over,
  output logic             err_rx_over,
  output logic             err_rx_under
);
  logic [1:0]  rst_sync;
  logic        rst_n_i;
  cmd_word_t   tx_head;
  logic        tx_full, tx_empty, rx_full, rx_empty, tx_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  i2cm_q_fifo #(.WIDTH(CMD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n_i),
    .push(cmd_wr_en), .push_data(cmd_word),
    .pop(tx_pop), .flush(abort),
    .head(tx_head), .level(tx_level),
    .full(tx_full), .empty(tx_empty)
  );

  i2cm_q_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n_i),
    .push(seq_rx_valid), .push_data(seq_rx_byte),
    .pop(rx_rd_en), .flush(abort),
    .head(rx_data), .level(rx_level),
    .full(rx_full), .empty(rx_empty)
  );

  i2cm_q_status #(.LW(LW)) u_stat (
    .clk(clk), .rst_n(rst_n_i),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
    .tx_full(tx_full), .rx_full(rx_full), .rx_empty(rx_empty),
    .tx_push(cmd_wr_en), .rx_push(seq_rx_valid), .rx_pop(rx_rd_en),
    .flush(abort),
    .tx_low(tx_low), .rx_high(rx_high),
    .err_tx_over(err_tx_over), .err_rx_over(err_rx_over),
    .err_rx_under(err_rx_under)
  );

  always_comb begin
    seq_valid   = !tx_empty;
    tx_pop      = seq_valid && seq_ready && !abort;
    seq_read    = tx_head.read;
    seq_stop    = tx_head.stop;
    seq_restart = tx_head.restart;
    seq_data    = tx_head.read ? 8'h00 : tx_head.data;
  end

  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n_i)
    (seq_valid && !seq_ready && !abort) |=>
      (seq_valid && $stable(seq_data) && $stable(seq_read) &&
       $stable(seq_stop) && $stable(seq_restart)));

  assert_one_pop_R11: assert property (@(posedge clk) disable iff (!rst_n_i)
    (seq_valid && seq_ready && !abort && !cmd_wr_en) |=>
      (tx_level == $past(tx_level) - 1'b1));

  assert_under_keeps_empty_R9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rx_rd_en && rx_level == '0 && !seq_rx_valid) |=> (rx_level == '0));
endmodule

// File: tb/i2cm_cmd_queue_tb.sv
module i2cm_cmd_queue_tb;
  localparam int CLK_P = 10;
  localparam int DEPTH = 8;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk, rst_n;
  logic          cmd_wr_en, rx_rd_en, abort, seq_ready, seq_rx_valid;
  logic [10:0]   cmd_word;
  logic [7:0]    rx_data, seq_data, seq_rx_byte;
  logic [LW-1:0] tx_thresh, rx_thresh, tx_level, rx_level;
  logic          tx_low, rx_high, seq_valid, seq_read, seq_stop, seq_restart;
  logic          err_tx_over, err_rx_over, err_rx_under;

  int n_chk  = 0;
  int n_fail = 0;

  i2cm_cmd_queue #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr_en(cmd_wr_en), .cmd_word(cmd_word),
    .rx_rd_en(rx_rd_en), .rx_data(rx_data),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_low(tx_low), .rx_high(rx_high),
    .abort(abort),
    .seq_valid(seq_valid), .seq_ready(seq_ready),
    .seq_data(seq_data), .seq_read(seq_read),
    .seq_stop(seq_stop), .seq_restart(seq_restart),
    .seq_rx_valid(seq_rx_valid), .seq_rx_byte(seq_rx_byte),
    .err_tx_over(err_tx_over), .err_rx_over(err_rx_over),
    .err_rx_under(err_rx_under)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_cmd(input logic [10:0] w);
    cmd_wr_en = 1'b1; cmd_word = w;
    @(negedge clk);
    cmd_wr_en = 1'b0;
  endtask

  task automatic pop_cmd();
    seq_ready = 1'b1;
    @(negedge clk);
    seq_ready = 1'b0;
  endtask

  task automatic give_rx(input logic [7:0] b);
    seq_rx_valid = 1'b1; seq_rx_byte = b;
    @(negedge clk);
    seq_rx_valid = 1'b0;
  endtask

  task automatic take_rx();
    rx_rd_en = 1'b1;
    @(negedge clk);
    rx_rd_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 tx_level after reset", tx_level, 0);
    chk("R12 rx_level after reset", rx_level, 0);
    chk("R12 seq_valid after reset", seq_valid, 0);
    chk("R12 tx_low after reset", tx_low, 1);
    chk("R12 rx_high after reset", rx_high, 0);
    chk("R12 error pulses after reset", {err_tx_over, err_rx_over, err_rx_under}, 0);
  endtask

  task automatic t_order();
    tx_thresh = 4'd2;
    push_cmd(11'h4A5);            // restart, write A5
    push_cmd(11'h333);            // stop, read, data 33 ignored
    push_cmd(11'h05A);            // plain write 5A
    chk("R3 tx_level after 3 writes", tx_level, 3);
    chk("R4 tx_low at 3 > thresh 2", tx_low, 0);
    chk("R1 head data", seq_data, 8'hA5);
    chk("R1 head restart bit10", seq_restart, 1);
    chk("R1 head read bit8", seq_read, 0);
    chk("R1 head stop bit9", seq_stop, 0);
    @(negedge clk);
    chk("R11 held without ready", seq_data, 8'hA5);
    chk("R11 level held without ready", tx_level, 3);
    pop_cmd();
    chk("R11 one pop", tx_level, 2);
    chk("R4 tx_low at 2 <= thresh 2", tx_low, 1);
    chk("R1 second word read bit8", seq_read, 1);
    chk("R1 second word stop bit9", seq_stop, 1);
    chk("R2 read data presented as zero", seq_data, 0);
    pop_cmd();
    chk("R1 third word data", seq_data, 8'h5A);
    chk("R1 third word restart", seq_restart, 0);
    pop_cmd();
    chk("R3 tx_level drained", tx_level, 0);
    chk("R11 valid drops when empty", seq_valid, 0);
  endtask

  task automatic t_rx();
    rx_thresh = 4'd0;
    chk("R5 rx_high empty thresh 0", rx_high, 0);
    give_rx(8'h11);
    chk("R5 rx_high one byte thresh 0", rx_high, 1);
    rx_thresh = 4'd2;
    give_rx(8'h22);
    chk("R5 rx_high 2 bytes thresh 2", rx_high, 0);
    give_rx(8'h33);
    chk("R5 rx_high 3 bytes thresh 2", rx_high, 1);
    chk("R3 rx_level", rx_level, 3);
    chk("R7 oldest byte", rx_data, 8'h11);
    take_rx();
    chk("R7 next byte", rx_data, 8'h22);
    take_rx();
    chk("R7 last byte", rx_data, 8'h33);
    take_rx();
    chk("R3 rx_level drained", rx_level, 0);
  endtask

  task automatic t_rx_under();
    take_rx();
    chk("R9 under pulse", err_rx_under, 1);
    chk("R9 rx_level stays 0", rx_level, 0);
    @(negedge clk);
    chk("R9 under pulse one cycle", err_rx_under, 0);
  endtask

  task automatic t_tx_over();
    for (int i = 0; i < DEPTH; i++) push_cmd(11'(i + 8'h40));
    chk("R8 full level", tx_level, DEPTH);
    chk("R8 no pulse while filling", err_tx_over, 0);
    push_cmd(11'h0EE);
    chk("R8 over pulse", err_tx_over, 1);
    chk("R8 level unchanged", tx_level, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R8 stored order after drop", seq_data, i + 8'h40);
      pop_cmd();
    end
    chk("R8 dropped word absent", seq_valid, 0);
    chk("R8 over pulse cleared", err_tx_over, 0);
  endtask

  task automatic t_rx_over_abort();
    for (int i = 0; i < DEPTH; i++) give_rx(8'(i + 8'h80));
    give_rx(8'hFE);
    chk("R10 rx over pulse", err_rx_over, 1);
    chk("R10 rx level unchanged", rx_level, DEPTH);
    chk("R10 oldest kept", rx_data, 8'h80);
    push_cmd(11'h011);
    push_cmd(11'h022);
    abort = 1'b1; seq_ready = 1'b1; rx_rd_en = 1'b1;
    @(negedge clk);
    abort = 1'b0; seq_ready = 1'b0; rx_rd_en = 1'b0;
    chk("R6 tx flushed", tx_level, 0);
    chk("R6 rx flushed", rx_level, 0);
    chk("R6 valid dropped", seq_valid, 0);
    chk("R6 no under pulse on abort", err_rx_under, 0);
    give_rx(8'h5C);
    chk("R6 fresh byte after flush", rx_data, 8'h5C);
    take_rx();
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_wr_en = 1'b0; cmd_word = '0; rx_rd_en = 1'b0;
    abort = 1'b0; seq_ready = 1'b0; seq_rx_valid = 1'b0; seq_rx_byte = '0;
    tx_thresh = '0; rx_thresh = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_order();
    t_rx();
    t_rx_under();
    t_tx_over();
    t_rx_over_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule